// File: doc/BRIEF.md
# Mode-Selectable Serial Code Receiver

This block receives one compressed speech code word per frame from a serial line. A framing strobe marks each frame. While the strobe is high, a bit clock shifts data in, one bit on each falling edge of the bit clock. When the strobe falls, the receiver takes the word from the most recent bits it has received. A two-bit mode input sets the word width to 2, 3, 4 or 5 bits. The result appears right-aligned on a 5-bit output, together with a valid pulse that lasts one clock cycle.

The bit clock, the serial data and the strobe are asynchronous to the system clock. Each passes through a two-flop synchronizer, and its edges are detected in the system-clock domain. Alignment comes only from the strobe's falling edge. No start marker is used. Any bits received before the last five are dropped.

Top module: `serial_code_rx`

## Requirements
- R1: The history takes a new bit only on a falling edge of the bit clock, and that bit is the serial data level at that edge. Data that changes while the bit clock is high or rising is not captured until the next falling edge.
- R2: The history holds five slots. The newest bit is slot 0 and the oldest is slot 4. Each newly captured bit enters slot 0 and moves the older bits up by one.
- R3: With mode 00 the word is 4 bits wide and equals slots 3..0. The last bit before the strobe fell is the LSB.
- R4: With mode 01 the word is 3 bits wide and equals slots 3..1. The final slot is don't-care.
- R5: With mode 10 the word is 2 bits wide and equals slots 3..2. The two final slots are don't-care.
- R6: With mode 11 the word is 5 bits wide and equals slots 4..0.
- R7: The word is right-aligned on the 5-bit output, and every output bit above the word width is 0.
- R8: Bits received before the last five have no effect on the word.
- R9: Each falling edge of the strobe produces exactly one valid pulse, one system-clock cycle long. No pulse occurs at any other time, and the word output changes only together with a pulse.
- R10: An active-low synchronous reset clears the history, the word output and the valid output.
- R11: The mode is taken at the moment the strobe's falling edge is detected. Changes to the mode earlier in the frame have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Asynchronous bit clock; data is sampled on its falling edge |
| sdata_i | input | 1 | Asynchronous serial data |
| frame_i | input | 1 | Asynchronous framing strobe; its falling edge closes a word |
| mode_i | input | 2 | Word width select: 00=4, 01=3, 10=2, 11=5 bits |
| word_o | output | 5 | Right-aligned received word, zero-filled above the width |
| valid_o | output | 1 | One-cycle pulse when word_o is updated |

## Verification
The bench sweeps every 5-bit pattern in every mode, preceded by zero to three extra leading bits. A receiver that aligned on the first bit instead of the last would return a shifted word. Changing the mode in the middle of a frame checks that the width is taken at the strobe's fall. A design that registered the mode early would truncate the word at the wrong width. Bit clock activity without a strobe fall, and a strobe fall straight after reset, show whether pulses are spurious and whether the history is actually cleared.

// File: rtl/serial_code_rx.sv
module serial_code_rx #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bclk_i,
  input  logic       sdata_i,
  input  logic       frame_i,
  input  logic [1:0] mode_i,
  output logic [4:0] word_o,
  output logic       valid_o
);
  localparam int TOP = SYNC_STAGES;

  logic [TOP:0] bclk_sr, sd_sr, fr_sr;
  logic [4:0]   hist;
  logic [4:0]   word_nxt;
  logic         bclk_fall, frame_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_sr <= '1;
      sd_sr   <= '0;
      fr_sr   <= '0;
    end else begin
      bclk_sr <= {bclk_sr[TOP-1:0], bclk_i};
      sd_sr   <= {sd_sr[TOP-1:0], sdata_i};
      fr_sr   <= {fr_sr[TOP-1:0], frame_i};
    end
  end

  assign bclk_fall  = bclk_sr[TOP] & ~bclk_sr[TOP-1];
  assign frame_fall = fr_sr[TOP] & ~fr_sr[TOP-1];

  always_ff @(posedge clk) begin
    if (!rst_n)         hist <= '0;
    else if (bclk_fall) hist <= {hist[3:0], sd_sr[TOP-1]};
  end

  always_comb begin
    case (mode_i)
      2'b00:   word_nxt = {1'b0, hist[3:0]};
      2'b01:   word_nxt = {2'b00, hist[3:1]};
      2'b10:   word_nxt = {3'b000, hist[3:2]};
      default: word_nxt = hist;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= frame_fall;
      if (frame_fall) word_o <= word_nxt;
    end
  end
endmodule

module serial_code_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_i,
  input logic [4:0] word_o,
  input logic       valid_o,
  input logic       bclk_fall,
  input logic       frame_fall,
  input logic [4:0] hist
);
  assert_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_fall |=> hist[4:1] == $past(hist[3:0]));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk_fall |=> $stable(hist));
  assert_width4_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(mode_i) == 2'b00) |-> word_o[4] == 1'b0);
  assert_width3_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(mode_i) == 2'b01) |-> word_o[4:3] == 2'b00);
  assert_width2_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(mode_i) == 2'b10) |-> word_o[4:2] == 3'b000);
  assert_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && $past(mode_i) == 2'b11) |-> word_o == $past(hist));
  assert_one_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  assert_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(frame_fall));
  assert_word_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_fall |=> $stable(word_o));
  assert_reset_R10: assert property (@(posedge clk)
    !rst_n |=> (!valid_o && word_o == 5'd0 && hist == 5'd0));
endmodule

bind serial_code_rx serial_code_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .word_o(word_o),
  .valid_o(valid_o), .bclk_fall(bclk_fall), .frame_fall(frame_fall),
  .hist(hist)
);

// File: tb/serial_code_rx_tb_top.sv
module serial_code_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bclk_i = 1'b1;
  logic       sdata_i = 1'b0;
  logic       frame_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic [4:0] word_o;
  logic       valid_o;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serial_code_rx dut_i (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .sdata_i(sdata_i),
    .frame_i(frame_i), .mode_i(mode_i), .word_o(word_o), .valid_o(valid_o)
  );

  always @(negedge clk) if (rst_n && valid_o) pulses++;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    bclk_i = 1'b1;
    sdata_i = b;
    wait_clk(4);
    bclk_i = 1'b0;
    wait_clk(4);
  endtask

  task automatic close_frame(output int got, output int npulse);
    int p0;
    bclk_i = 1'b1;
    wait_clk(4);
    p0 = pulses;
    frame_i = 1'b0;
    wait_clk(10);
    got = word_o;
    npulse = pulses - p0;
    frame_i = 1'b1;
    wait_clk(4);
  endtask

  function automatic int expect_word(input int m, input int p);
    case (m)
      0: return p & 15;
      1: return (p >> 1) & 7;
      2: return (p >> 2) & 3;
      default: return p;
    endcase
  endfunction

  initial begin
    int got, np, p0;
    wait_clk(4);
    check("R10 reset word", word_o, 0);
    check("R10 reset valid", valid_o, 0);
    rst_n = 1'b1;
    wait_clk(3);
    mode_i = 2'b11;
    frame_i = 1'b1;
    wait_clk(6);
    close_frame(got, np);
    check("R10 empty history word", got, 0);
    check("R9 pulse count", np, 1);

    for (int m = 0; m < 4; m++) begin
      mode_i = m[1:0];
      for (int p = 0; p < 32; p++) begin
        for (int lead = 0; lead < 4; lead++) begin
          for (int k = 0; k < lead; k++) send_bit(((p + k) & 1) == 0);
          for (int k = 4; k >= 0; k--) send_bit(p[k]);
          close_frame(got, np);
          case (m)
            0: check("R3 R2 R8 4-bit word", got, expect_word(m, p));
            1: check("R4 R8 3-bit word", got, expect_word(m, p));
            2: check("R5 R8 2-bit word", got, expect_word(m, p));
            default: check("R6 R7 R8 5-bit word", got, expect_word(m, p));
          endcase
          check("R9 one pulse", np, 1);
        end
      end
    end

    p0 = pulses;
    for (int k = 0; k < 6; k++) send_bit(k[0]);
    wait_clk(10);
    check("R9 no pulse without strobe fall", pulses - p0, 0);

    mode_i = 2'b11;
    for (int k = 4; k >= 0; k--) send_bit(5'b10110 >> k & 1);
    mode_i = 2'b10;
    close_frame(got, np);
    check("R11 late mode change", got, 2'b01);

    for (int k = 4; k >= 0; k--) begin
      bclk_i = 1'b1;
      sdata_i = ~(5'b01101 >> k & 1);
      wait_clk(2);
      sdata_i = 5'b01101 >> k & 1;
      wait_clk(2);
      bclk_i = 1'b0;
      wait_clk(4);
    end
    mode_i = 2'b11;
    close_frame(got, np);
    check("R1 falling-edge sampling", got, 5'b01101);

    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 190000; i++) begin
      @(negedge clk);
      if (done) break;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule